// File: doc/BRIEF.md
# Multi-CPU level-one interrupt router

The block gathers a parameterised set of level-sensitive interrupt sources, grouped 32 to a word, and forwards them to one or two processors. Every processor owns a private register bank on a simple 32-bit memory-mapped port. The bank holds a set of enable words and, right after them, a set of read-only status words. A source reaches a processor only when its level is high and that processor's enable bit for it is set. Each processor has its own interrupt line: the registered OR of all of its pending bits.

Software picks the processor that should handle a source by setting the matching enable bit in that processor's bank. Nothing stops the same source from being enabled in both banks. An enable word is written whole; no set or clear aliases exist. Within a bank the word numbering runs downward: the first word covers the highest group of 32 sources and the last word covers sources 0 to 31.

Top module: `l1irq_router`

## Requirements
- R1: After reset every enable bit of every CPU is 0, and every `cpu_irq` bit is 0, even with all sources high.
- R2: A write to an enable word replaces all 32 bits of that word with `bus_wdata`, and a read of the same word returns that value.
- R3: With N = `NUM_WORDS`, CPU c's bank starts at byte `c*8*N`. The enable word for group g sits at bank offset `(N-1-g)*4`, and the status word for group g sits at bank offset `N*4 + (N-1-g)*4`. Group g covers sources `32*g` to `32*g+31`, with bit b of the word being source `32*g+b`. Address bits [1:0] are ignored.
- R4: A status word reads the raw levels of its 32 sources, whatever the enable bits of either CPU hold, and reads the same in both CPUs' banks.
- R5: A write to a status address changes no enable bit and no status readback.
- R6: `cpu_irq[c]` is 1 exactly when some source is high and enabled in CPU c's bank. It follows a source change at the next rising edge, and an enable write one edge after the edge that performs the write.
- R7: A write to one CPU's bank leaves the other CPU's enables and interrupt line unchanged. Enable bits of the two CPUs are independent, so a source enabled in both banks raises both lines.
- R8: A read at a byte address at or beyond `NUM_CPUS*8*N` returns 0, and a write there has no effect.
- R9: `bus_ready` equals `bus_valid`. A read returns its data in the same cycle, and a write takes effect at the rising edge at which `bus_valid` and `bus_write` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_level | input | 32*NUM_WORDS | Level of each interrupt source |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted this cycle |
| bus_rdata | output | 32 | Read data, 0 when no read is under way |
| cpu_irq | output | NUM_CPUS | Interrupt line of each CPU |

## Verification
The checker checks four rules on every cycle. Each interrupt line matches the previous cycle's enabled-and-high sources. Any write to an enable word lands in exactly the addressed group of the addressed CPU and leaves every other bank stable. A status read returns the raw source levels. Writes to status or unmapped addresses leave all enables unchanged, and unmapped reads return zero. Only the bench's scenarios show the end-to-end effects: the downward word numbering seen as one source at a time raising the right line, the reset state under fully active sources, the one-edge latency after an enable write, and both lines firing for a source enabled in both banks.

// File: rtl/l1irq_pkg.sv
`timescale 1ns/1ps
package l1irq_pkg;

  localparam int GROUP_BITS = 32;

  // Words in one CPU bank: enables then status.
  function automatic int bank_words(int n_words);
    return 2 * n_words;
  endfunction

  // Which CPU bank a word index falls into.
  function automatic int bank_of(int widx, int n_words);
    return widx / bank_words(n_words);
  endfunction

  // Position of the word inside its bank.
  function automatic int slot_of(int widx, int n_words);
    return widx % bank_words(n_words);
  endfunction

  // Status words occupy the upper half of a bank.
  function automatic bit slot_is_status(int slot, int n_words);
    return slot >= n_words;
  endfunction

  // Bank words run from the highest group down to group 0.
  function automatic int group_of_slot(int slot, int n_words);
    return n_words - 1 - (slot % n_words);
  endfunction

endpackage

// File: rtl/l1irq_decode.sv
`timescale 1ns/1ps
module l1irq_decode #(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 8,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int GRP_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              is_status,
  output logic [CPU_W-1:0]  cpu,
  output logic [GRP_W-1:0]  group
);
  import l1irq_pkg::*;

  localparam int MAPPED_WORDS = NUM_CPUS * 2 * NUM_WORDS;

  int widx;
  int slot;

  always_comb begin
    widx      = int'(addr[ADDR_W-1:2]);
    slot      = slot_of(widx, NUM_WORDS);
    hit       = widx < MAPPED_WORDS;
    is_status = slot_is_status(slot, NUM_WORDS);
    cpu       = CPU_W'(bank_of(widx, NUM_WORDS));
    group     = GRP_W'(group_of_slot(slot, NUM_WORDS));
  end

endmodule

// File: rtl/l1irq_enable_bank.sv
`timescale 1ns/1ps
module l1irq_enable_bank #(
  parameter int NUM_WORDS = 2,
  localparam int SRC_N    = 32 * NUM_WORDS,
  localparam int GRP_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [GRP_W-1:0] wr_group,
  input  logic [31:0]      wr_data,
  output logic [SRC_N-1:0] enables
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enables <= '0;
    end else if (wr_en) begin
      for (int g = 0; g < NUM_WORDS; g++) begin
        if (wr_group == GRP_W'(g)) begin
          enables[g*32 +: 32] <= wr_data;
        end
      end
    end
  end

endmodule

// File: rtl/l1irq_irq_out.sv
`timescale 1ns/1ps
module l1irq_irq_out #(
  parameter int NUM_WORDS = 2,
  localparam int SRC_N    = 32 * NUM_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_level,
  input  logic [SRC_N-1:0] enables,
  output logic             pend_any,
  output logic             irq
);

  logic [SRC_N-1:0] pending;

  assign pending  = src_level & enables;
  assign pend_any = |pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= pend_any;
    end
  end

endmodule

// File: rtl/l1irq_router.sv
`timescale 1ns/1ps
module l1irq_router #(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [32*NUM_WORDS-1:0] src_level,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic                    bus_ready,
  output logic [31:0]             bus_rdata,
  output logic [NUM_CPUS-1:0]     cpu_irq
);

  localparam int SRC_N = 32 * NUM_WORDS;
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
  localparam int GRP_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  // Named internal events for the checker and for waveform reading.
  logic                      dec_hit;
  logic                      dec_status;
  logic [CPU_W-1:0]          dec_cpu;
  logic [GRP_W-1:0]          dec_group;
  logic                      enable_wr;
  logic                      read_req;
  logic [NUM_CPUS*SRC_N-1:0] en_all;
  logic [NUM_CPUS-1:0]       pend_any;

  l1irq_decode #(
    .NUM_WORDS(NUM_WORDS),
    .NUM_CPUS (NUM_CPUS),
    .ADDR_W   (ADDR_W)
  ) u_decode (
    .addr     (bus_addr),
    .hit      (dec_hit),
    .is_status(dec_status),
    .cpu      (dec_cpu),
    .group    (dec_group)
  );

  assign bus_ready = bus_valid;
  assign enable_wr = bus_valid & bus_write & dec_hit & ~dec_status;
  assign read_req  = bus_valid & ~bus_write & dec_hit;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic bank_wr;
    assign bank_wr = enable_wr && (dec_cpu == CPU_W'(c));

    l1irq_enable_bank #(.NUM_WORDS(NUM_WORDS)) u_enables (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_wr),
      .wr_group(dec_group),
      .wr_data (bus_wdata),
      .enables (en_all[c*SRC_N +: SRC_N])
    );

    l1irq_irq_out #(.NUM_WORDS(NUM_WORDS)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_level(src_level),
      .enables  (en_all[c*SRC_N +: SRC_N]),
      .pend_any (pend_any[c]),
      .irq      (cpu_irq[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (read_req) begin
      if (dec_status) begin
        bus_rdata = src_level[int'(dec_group)*32 +: 32];
      end else begin
        bus_rdata = en_all[int'(dec_cpu)*SRC_N + int'(dec_group)*32 +: 32];
      end
    end
  end

endmodule

// File: rtl/l1irq_checker.sv
`timescale 1ns/1ps
module l1irq_checker #(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [32*NUM_WORDS-1:0]       src_level,
  input logic                          bus_valid,
  input logic                          bus_write,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [31:0]                   bus_wdata,
  input logic [31:0]                   bus_rdata,
  input logic [NUM_CPUS*32*NUM_WORDS-1:0] en_all,
  input logic [NUM_CPUS-1:0]           cpu_irq
);

  localparam int SRC_N = 32 * NUM_WORDS;
  localparam int BANK  = 2 * NUM_WORDS;
  localparam int LIMIT = NUM_CPUS * BANK;

  int  word_i;
  logic wr_any, rd_any, wr_no_enable, rd_unmapped;

  always_comb begin
    word_i       = int'(bus_addr[ADDR_W-1:2]);
    wr_any       = bus_valid && bus_write;
    rd_any       = bus_valid && !bus_write;
    wr_no_enable = wr_any && ((word_i >= LIMIT) || ((word_i % BANK) >= NUM_WORDS));
    rd_unmapped  = rd_any && (word_i >= LIMIT);
  end

  // R5, R8: writes that miss every enable word leave all enables alone
  a_r5_no_enable_change: assert property (@(posedge clk) disable iff (!rst_n)
    wr_no_enable |=> $stable(en_all));

  // R8: unmapped reads return zero
  a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |-> bus_rdata == 32'h0);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_c
    // R6: line reflects last cycle's enabled-and-high sources
    a_r6_irq_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cpu_irq[c] == (|($past(src_level) & $past(en_all[c*SRC_N +: SRC_N]))));

    // R7: a write aimed at another bank leaves this bank stable
    a_r7_other_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && (word_i / BANK != c)) |=> $stable(en_all[c*SRC_N +: SRC_N]));

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
      // R2, R3: an enable write lands whole in the addressed group
      a_r2_enable_replaced: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && word_i == c*BANK + w)
        |=> en_all[c*SRC_N + (NUM_WORDS-1-w)*32 +: 32] == $past(bus_wdata));

      // R4: status reads show raw levels
      a_r4_status_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && word_i == c*BANK + NUM_WORDS + w)
        |-> bus_rdata == src_level[(NUM_WORDS-1-w)*32 +: 32]);
    end
  end

endmodule

bind l1irq_router l1irq_checker #(
  .NUM_WORDS(NUM_WORDS),
  .NUM_CPUS (NUM_CPUS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_level(src_level),
  .bus_valid(bus_valid),
  .bus_write(bus_write),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .en_all   (en_all),
  .cpu_irq  (cpu_irq)
);

// File: tb/l1irq_router_test.sv
`timescale 1ns/1ps
module l1irq_router_test;

  localparam int NW = 2;
  localparam int NC = 2;
  localparam int AW = 8;
  localparam int SN = 32 * NW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SN-1:0] src_level = '0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_ready;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] cpu_irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  l1irq_router #(.NUM_WORDS(NW), .NUM_CPUS(NC), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .src_level(src_level),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq)
  );

  // Address map restated from R3: bank of 8*NW bytes per CPU.
  function automatic logic [AW-1:0] en_addr(int cpu, int grp);
    return AW'(cpu * 8 * NW + 4 * ((NW - 1) - grp));
  endfunction

  function automatic logic [AW-1:0] st_addr(int cpu, int grp);
    return AW'(cpu * 8 * NW + 4 * NW + 4 * ((NW - 1) - grp));
  endfunction

  function automatic logic [31:0] pat(int cpu, int grp, int k);
    return 32'h9E3779B9 * (cpu * 7 + grp * 3 + k + 1);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic clear_all();
    for (int c = 0; c < NC; c++)
      for (int g = 0; g < NW; g++) wr(en_addr(c, g), 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, even with all sources high
    src_level = '1;
    repeat (2) @(negedge clk);
    check("R1 irq after reset", 32'(cpu_irq), 32'h0);
    for (int c = 0; c < NC; c++)
      for (int g = 0; g < NW; g++) begin
        rd(en_addr(c, g), d);
        check("R1 enable after reset", d, 32'h0);
      end

    // R9: handshake
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = st_addr(0, 0);
    #1 check("R9 ready follows valid", 32'(bus_ready), 32'h1);
    bus_valid = 1'b0;
    #1 check("R9 ready low when idle", 32'(bus_ready), 32'h0);
    src_level = '0;

    // R2, R7: whole-word replace, independent banks
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < NC; c++)
        for (int g = 0; g < NW; g++) wr(en_addr(c, g), pat(c, g, k));
      for (int c = 0; c < NC; c++)
        for (int g = 0; g < NW; g++) begin
          rd(en_addr(c, g), d);
          check("R2 enable readback", d, pat(c, g, k));
        end
    end
    wr(en_addr(0, 0), 32'h0000_0001);
    rd(en_addr(1, 0), d);
    check("R7 other bank untouched", d, pat(1, 0, 1));
    rd(en_addr(0, 1), d);
    check("R7 sibling word untouched", d, pat(0, 1, 1));

    // R4: status raw regardless of enables, same in both banks
    src_level = {32'hDEAD_BEEF, 32'h1234_5678};
    for (int c = 0; c < NC; c++)
      for (int g = 0; g < NW; g++) begin
        rd(st_addr(c, g), d);
        check("R4 status raw", d, src_level[g*32 +: 32]);
      end
    clear_all();
    for (int c = 0; c < NC; c++)
      for (int g = 0; g < NW; g++) begin
        rd(st_addr(c, g), d);
        check("R4 status raw enables clear", d, src_level[g*32 +: 32]);
      end
    // R3: address bits [1:0] ignored
    rd(st_addr(0, 1) | AW'(3), d);
    check("R3 low address bits ignored", d, src_level[63:32]);

    // R5: writes to status addresses ignored
    src_level = '0;
    for (int c = 0; c < NC; c++)
      for (int g = 0; g < NW; g++) wr(st_addr(c, g), 32'hFFFF_FFFF);
    for (int c = 0; c < NC; c++)
      for (int g = 0; g < NW; g++) begin
        rd(en_addr(c, g), d);
        check("R5 enable after status write", d, 32'h0);
        rd(st_addr(c, g), d);
        check("R5 status after status write", d, 32'h0);
      end

    // R3, R6, R7: sweep every source on every CPU
    for (int s = 0; s < SN; s++) begin
      for (int c = 0; c < NC; c++) begin
        src_level = SN'(1) << s;
        wr(en_addr(c, s / 32), 32'h1 << (s % 32));
        check("R6 latency after enable write", 32'(cpu_irq), 32'h0);
        @(negedge clk);
        check("R3 R6 source routed", 32'(cpu_irq), 32'h1 << c);
        src_level = '0;
        @(negedge clk);
        check("R6 line drops with source", 32'(cpu_irq), 32'h0);
        src_level = SN'(1) << (s ^ 1);
        repeat (2) @(negedge clk);
        check("R6 unenabled neighbour masked", 32'(cpu_irq), 32'h0);
        src_level = '0;
        wr(en_addr(c, s / 32), 32'h0);
      end
    end

    // R7: same source enabled on both CPUs
    src_level = SN'(1) << 40;
    wr(en_addr(0, 1), 32'h100);
    wr(en_addr(1, 1), 32'h100);
    @(negedge clk);
    check("R7 both lines", 32'(cpu_irq), 32'h3);
    wr(en_addr(0, 1), 32'h0);
    @(negedge clk);
    check("R7 cpu1 stays after cpu0 cleared", 32'(cpu_irq), 32'h2);
    clear_all();

    // R8: unmapped addresses
    src_level = '1;
    for (int a = NC * 8 * NW; a < (1 << AW); a += 4) begin
      wr(AW'(a), 32'hFFFF_FFFF);
      rd(AW'(a), d);
      check("R8 unmapped read zero", d, 32'h0);
    end
    check("R8 irq after unmapped writes", 32'(cpu_irq), 32'h0);
    for (int c = 0; c < NC; c++)
      for (int g = 0; g < NW; g++) begin
        rd(en_addr(c, g), d);
        check("R8 enables after unmapped writes", d, 32'h0);
      end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule